// File: doc/BRIEF.md
# Pixel Component Extractor

This block turns raw framebuffer pixel words into an 8-bit red, green and blue triple. Each colour channel has its own 32-bit select word with three fields: a bit offset, a component length and a fallback value. The channel takes `len` bits of the pixel word, starting at `ofs`. It then scales the result to the 8-bit output width.

A pixel-format word gives the pixel size as a number of bytes, from 1 to 4. Pixel-word bits at or above that size are treated as zero. Each pixel arrives with two qualifiers: a visible-area flag and an underrun flag. When a qualifier says the pixel data is not usable, or when the component length is zero, the channel's fallback value is output in place of the extracted data.

The result is registered. It appears one clock after the input strobe, together with a valid strobe.

Top module: `pxe_extractor`

## Requirements
- R1: Select word layout: bits 4:0 hold the offset of the lowest extracted bit, bits 11:8 hold the component length, and bits 23:16 hold the fallback value. With length 8, the output equals pixel bits ofs+7..ofs.
- R2: Pixel-format bits 4:3 hold the number of bytes per pixel minus one, so 0 means 1 byte. Pixel bits at or above 8 × bytes read as zero, and bit positions above 31 also read as zero.
- R3: A component of 1 to 7 bits is placed in the top bits of the output. The lower output bits are filled by repeating the component from its MSB down, for example 3'b101 becomes 8'hB6.
- R4: A component of 9 to 15 bits is reduced to its 8 most significant bits.
- R5: A length field of 0 outputs the channel's fallback value.
- R6: A pixel with the visible flag low outputs the fallback value on every channel.
- R7: A pixel with the underrun flag high outputs the fallback value on every channel, whatever the visible flag is.
- R8: `rgb_valid_o` goes high exactly one clock after a cycle with `pix_valid_i` high, and is low otherwise.
- R9: After reset all outputs are zero. While `pix_valid_i` is low, the colour outputs keep their last values.
- R10: The three channels are fully independent: each uses only its own select word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pixfmt_i | input | 8 | Pixel format word; bits 4:3 hold bytes per pixel minus one |
| sel_red_i | input | 32 | Red select word |
| sel_grn_i | input | 32 | Green select word |
| sel_blu_i | input | 32 | Blue select word |
| pix_valid_i | input | 1 | Pixel word strobe |
| pix_data_i | input | 32 | Raw pixel word |
| pix_visible_i | input | 1 | Pixel lies in the visible area |
| pix_underrun_i | input | 1 | Pixel source underran |
| red_o | output | 8 | Red component |
| grn_o | output | 8 | Green component |
| blu_o | output | 8 | Blue component |
| rgb_valid_o | output | 1 | Output strobe |

## Verification
The bench builds the block with its default parameters: a 4-byte pixel word and 8-bit components. With these values every offset from 0 to 31 can be combined with every length up to 15, so fields that run past bit 31 are reachable. A 1-byte format placed under a 4-byte word exercises the byte masking. Lengths 1, 2, 3, 5, 6, 9, 12 and 15 cover bit replication and truncation, and each fallback condition is exercised separately with a different value per channel.

// File: rtl/pxe_pkg.sv
package pxe_pkg;
  localparam int SEL_W       = 32;
  localparam int OFS_W       = 5;
  localparam int LEN_W       = 4;
  localparam int DEF_W       = 8;
  localparam int SEL_OFS_LSB = 0;
  localparam int SEL_LEN_LSB = 8;
  localparam int SEL_DEF_LSB = 16;
  localparam int FMT_W       = 8;
  localparam int FMT_BPP_LSB = 3;
  localparam int NUM_CH      = 3;

  typedef struct packed {
    logic [DEF_W-1:0] dflt;
    logic [LEN_W-1:0] len;
    logic [OFS_W-1:0] ofs;
  } sel_t;

  typedef enum logic [1:0] {
    SRC_PIXEL    = 2'd0,
    SRC_NOLEN    = 2'd1,
    SRC_BLANK    = 2'd2,
    SRC_UNDERRUN = 2'd3
  } src_e;

  function automatic sel_t unpack_sel(input logic [SEL_W-1:0] w);
    sel_t s;
    s.ofs  = w[SEL_OFS_LSB +: OFS_W];
    s.len  = w[SEL_LEN_LSB +: LEN_W];
    s.dflt = w[SEL_DEF_LSB +: DEF_W];
    return s;
  endfunction
endpackage

// File: rtl/pxe_width_mask.sv
module pxe_width_mask #(
  parameter int MAX_BYTES = 4,
  parameter int BPP_W     = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
  localparam int PIX_W    = MAX_BYTES * 8
) (
  input  logic [BPP_W-1:0] bytes_m1_i,
  input  logic [PIX_W-1:0] data_i,
  output logic [PIX_W-1:0] data_o
);
  // keep byte b only when it lies within the programmed pixel size
  for (genvar b = 0; b < MAX_BYTES; b++) begin : g_byte
    logic keep;
    assign keep = (int'(bytes_m1_i) >= b);
    assign data_o[b*8 +: 8] = keep ? data_i[b*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/pxe_field_extract.sv
module pxe_field_extract #(
  parameter int PIX_W  = 32,
  parameter int OFS_W  = 5,
  parameter int LEN_W  = 4,
  parameter int COMP_W = 8,
  localparam int MAXLEN = (1 << LEN_W) - 1,
  localparam int EXT_W  = PIX_W + MAXLEN
) (
  input  logic [PIX_W-1:0]  data_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [COMP_W-1:0] comp_o
);
  logic [EXT_W-1:0]  ext;
  logic [MAXLEN-1:0] lmask;
  logic [MAXLEN-1:0] field;
  logic [COMP_W-1:0] aligned;
  logic [COMP_W-1:0] narrow;
  logic [COMP_W-1:0] wide;
  int                len_n;

  assign len_n = int'(len_i);
  // zero extension keeps positions beyond the word at zero
  assign ext   = EXT_W'(data_i) >> ofs_i;
  assign lmask = MAXLEN'((EXT_W'(1) << len_i) - EXT_W'(1));
  assign field = ext[MAXLEN-1:0] & lmask;

  always_comb begin
    aligned = '0;
    if (len_n <= COMP_W) aligned = COMP_W'(field << (COMP_W - len_n));
  end

  // MSB replication: OR successive copies shifted by the length
  always_comb begin
    narrow = '0;
    for (int j = 0; j < COMP_W; j++) begin
      if (len_n != 0 && j * len_n < COMP_W) narrow |= aligned >> (j * len_n);
    end
  end

  always_comb begin
    wide = '0;
    if (len_n > COMP_W) wide = COMP_W'(field >> (len_n - COMP_W));
  end

  generate
    if (MAXLEN > COMP_W) begin : g_trunc
      assign comp_o = (len_n > COMP_W) ? wide : narrow;
    end else begin : g_no_trunc
      assign comp_o = narrow;
    end
  endgenerate
endmodule

// File: rtl/pxe_source_select.sv
module pxe_source_select
  import pxe_pkg::*;
#(
  parameter int COMP_W = 8
) (
  input  logic [LEN_W-1:0]  len_i,
  input  logic              visible_i,
  input  logic              underrun_i,
  input  logic [COMP_W-1:0] comp_i,
  input  logic [COMP_W-1:0] dflt_i,
  output src_e              src_o,
  output logic [COMP_W-1:0] value_o
);
  always_comb begin
    if (underrun_i)       src_o = SRC_UNDERRUN;
    else if (!visible_i)  src_o = SRC_BLANK;
    else if (len_i == '0) src_o = SRC_NOLEN;
    else                  src_o = SRC_PIXEL;
  end

  assign value_o = (src_o == SRC_PIXEL) ? comp_i : dflt_i;
endmodule

// File: rtl/pxe_extractor.sv
module pxe_extractor
  import pxe_pkg::*;
#(
  parameter int MAX_BYTES = 4,
  parameter int COMP_W    = DEF_W,
  localparam int PIX_W    = MAX_BYTES * 8,
  localparam int BPP_W    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FMT_W-1:0]  pixfmt_i,
  input  logic [SEL_W-1:0]  sel_red_i,
  input  logic [SEL_W-1:0]  sel_grn_i,
  input  logic [SEL_W-1:0]  sel_blu_i,
  input  logic              pix_valid_i,
  input  logic [PIX_W-1:0]  pix_data_i,
  input  logic              pix_visible_i,
  input  logic              pix_underrun_i,
  output logic [COMP_W-1:0] red_o,
  output logic [COMP_W-1:0] grn_o,
  output logic [COMP_W-1:0] blu_o,
  output logic              rgb_valid_o
);
  logic [BPP_W-1:0]  bytes_m1;
  logic [PIX_W-1:0]  data_m;
  logic [SEL_W-1:0]  sel_w   [NUM_CH];
  logic [COMP_W-1:0] ch_val  [NUM_CH];
  logic [COMP_W-1:0] ch_q    [NUM_CH];

  assign bytes_m1 = pixfmt_i[FMT_BPP_LSB +: BPP_W];
  assign sel_w[0] = sel_red_i;
  assign sel_w[1] = sel_grn_i;
  assign sel_w[2] = sel_blu_i;

  pxe_width_mask #(.MAX_BYTES(MAX_BYTES), .BPP_W(BPP_W)) u_mask (
    .bytes_m1_i(bytes_m1),
    .data_i    (pix_data_i),
    .data_o    (data_m)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    sel_t              sel;
    logic [COMP_W-1:0] comp;
    src_e              src;

    assign sel = unpack_sel(sel_w[c]);

    pxe_field_extract #(
      .PIX_W (PIX_W),
      .OFS_W (OFS_W),
      .LEN_W (LEN_W),
      .COMP_W(COMP_W)
    ) u_ext (
      .data_i(data_m),
      .ofs_i (sel.ofs),
      .len_i (sel.len),
      .comp_o(comp)
    );

    pxe_source_select #(.COMP_W(COMP_W)) u_src (
      .len_i     (sel.len),
      .visible_i (pix_visible_i),
      .underrun_i(pix_underrun_i),
      .comp_i    (comp),
      .dflt_i    (COMP_W'(sel.dflt)),
      .src_o     (src),
      .value_o   (ch_val[c])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          ch_q[c] <= '0;
      else if (pix_valid_i) ch_q[c] <= ch_val[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rgb_valid_o <= 1'b0;
    else         rgb_valid_o <= pix_valid_i;
  end

  assign red_o = ch_q[0];
  assign grn_o = ch_q[1];
  assign blu_o = ch_q[2];
endmodule

// File: rtl/pxe_extractor_chk.sv
module pxe_extractor_chk #(
  parameter int PIX_W  = 32,
  parameter int COMP_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [7:0]        pixfmt_i,
  input logic [31:0]       sel_red_i,
  input logic [31:0]       sel_grn_i,
  input logic [31:0]       sel_blu_i,
  input logic              pix_valid_i,
  input logic [PIX_W-1:0]  pix_data_i,
  input logic              pix_visible_i,
  input logic              pix_underrun_i,
  input logic [COMP_W-1:0] red_o,
  input logic [COMP_W-1:0] grn_o,
  input logic [COMP_W-1:0] blu_o,
  input logic              rgb_valid_o
);
  p_valid_follows_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i |=> rgb_valid_o);

  p_valid_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |=> !rgb_valid_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |=> ($stable(red_o) && $stable(grn_o) && $stable(blu_o)));

  p_underrun_dflt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && pix_underrun_i) |=>
      (red_o == $past(sel_red_i[23:16]) && grn_o == $past(sel_grn_i[23:16])
       && blu_o == $past(sel_blu_i[23:16])));

  p_blank_dflt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && !pix_visible_i) |=>
      (red_o == $past(sel_red_i[23:16]) && grn_o == $past(sel_grn_i[23:16])
       && blu_o == $past(sel_blu_i[23:16])));

  p_nolen_dflt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && sel_red_i[11:8] == 4'd0) |=> (red_o == $past(sel_red_i[23:16])));

  p_byte0_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && pix_visible_i && !pix_underrun_i && sel_grn_i[11:8] == 4'd8
     && sel_grn_i[4:0] == 5'd0) |=> (grn_o == $past(pix_data_i[7:0])));
endmodule

bind pxe_extractor pxe_extractor_chk #(.PIX_W(PIX_W), .COMP_W(COMP_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pixfmt_i      (pixfmt_i),
  .sel_red_i     (sel_red_i),
  .sel_grn_i     (sel_grn_i),
  .sel_blu_i     (sel_blu_i),
  .pix_valid_i   (pix_valid_i),
  .pix_data_i    (pix_data_i),
  .pix_visible_i (pix_visible_i),
  .pix_underrun_i(pix_underrun_i),
  .red_o         (red_o),
  .grn_o         (grn_o),
  .blu_o         (blu_o),
  .rgb_valid_o   (rgb_valid_o)
);

// File: tb/tb_pxe_extractor.sv
module tb_pxe_extractor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pixfmt = '0;
  logic [31:0] sel_r = '0, sel_g = '0, sel_b = '0;
  logic        pix_valid = 1'b0;
  logic [31:0] pix_data = '0;
  logic        pix_vis = 1'b0;
  logic        pix_und = 1'b0;
  logic [7:0]  red, grn, blu;
  logic        rgb_valid;
  int          n_tests = 0;
  int          n_fail  = 0;

  always #10 clk = ~clk;

  pxe_extractor dut (
    .clk_i(clk), .rst_ni(rst_n), .pixfmt_i(pixfmt),
    .sel_red_i(sel_r), .sel_grn_i(sel_g), .sel_blu_i(sel_b),
    .pix_valid_i(pix_valid), .pix_data_i(pix_data),
    .pix_visible_i(pix_vis), .pix_underrun_i(pix_und),
    .red_o(red), .grn_o(grn), .blu_o(blu), .rgb_valid_o(rgb_valid)
  );

  function automatic logic [31:0] mk_sel(input logic [7:0] dflt, input logic [3:0] len,
                                         input logic [4:0] ofs);
    return {8'h00, dflt, 4'h0, len, 3'b000, ofs};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one pixel: inputs at a falling edge, captured at the next rising edge
  task automatic send(input logic [1:0] bm1, input logic [31:0] data, input logic vis,
                      input logic und);
    @(negedge clk);
    pixfmt    = {3'b000, bm1, 3'b000};
    pix_data  = data;
    pix_vis   = vis;
    pix_und   = und;
    pix_valid = 1'b1;
    @(negedge clk);
    pix_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R9", "reset red", red, 0);
    check("R9", "reset grn", grn, 0);
    check("R9", "reset blu", blu, 0);
    check("R8", "reset valid", rgb_valid, 0);
  endtask

  task automatic t_rgb565();
    sel_r = mk_sel(8'h11, 4'd5, 5'd11);
    sel_g = mk_sel(8'h22, 4'd6, 5'd5);
    sel_b = mk_sel(8'h33, 4'd5, 5'd0);
    send(2'd1, 32'h0000_F815, 1'b1, 1'b0);
    check("R8", "valid after pixel", rgb_valid, 1);
    check("R3", "565 red", red, 8'hFF);
    check("R10", "565 grn", grn, 8'h00);
    check("R3", "565 blu", blu, 8'hAD);
  endtask

  task automatic t_rgb888();
    sel_r = mk_sel(8'h00, 4'd8, 5'd16);
    sel_g = mk_sel(8'h00, 4'd8, 5'd8);
    sel_b = mk_sel(8'h00, 4'd8, 5'd0);
    send(2'd2, 32'h0012_3456, 1'b1, 1'b0);
    check("R1", "888 red", red, 8'h12);
    check("R1", "888 grn", grn, 8'h34);
    check("R1", "888 blu", blu, 8'h56);
  endtask

  task automatic t_width_mask();
    sel_r = mk_sel(8'h77, 4'd8, 5'd4);
    sel_g = mk_sel(8'h77, 4'd8, 5'd0);
    sel_b = mk_sel(8'h77, 4'd4, 5'd8);
    send(2'd0, 32'hFFFF_FF3C, 1'b1, 1'b0);
    check("R2", "1-byte red straddle", red, 8'h03);
    check("R2", "1-byte grn", grn, 8'h3C);
    check("R2", "1-byte blu above width", blu, 8'h00);
    sel_r = mk_sel(8'h77, 4'd8, 5'd28);
    sel_g = mk_sel(8'h77, 4'd8, 5'd24);
    sel_b = mk_sel(8'h77, 4'd1, 5'd31);
    send(2'd3, 32'hAB00_0000, 1'b1, 1'b0);
    check("R2", "past bit 31 red", red, 8'h0A);
    check("R2", "4-byte top grn", grn, 8'hAB);
    check("R3", "bit 31 len1 blu", blu, 8'hFF);
  endtask

  task automatic t_replicate();
    sel_r = mk_sel(8'h00, 4'd3, 5'd0);
    sel_g = mk_sel(8'h00, 4'd1, 5'd0);
    sel_b = mk_sel(8'h00, 4'd2, 5'd1);
    send(2'd0, 32'h0000_0005, 1'b1, 1'b0);
    check("R3", "len3 101", red, 8'hB6);
    check("R3", "len1 one", grn, 8'hFF);
    check("R3", "len2 10", blu, 8'hAA);
    sel_g = mk_sel(8'h00, 4'd1, 5'd1);
    send(2'd0, 32'h0000_0005, 1'b1, 1'b0);
    check("R3", "len1 zero", grn, 8'h00);
  endtask

  task automatic t_truncate();
    sel_r = mk_sel(8'h00, 4'd12, 5'd0);
    sel_g = mk_sel(8'h00, 4'd15, 5'd0);
    sel_b = mk_sel(8'h00, 4'd9, 5'd4);
    send(2'd1, 32'h0000_0ABC, 1'b1, 1'b0);
    check("R4", "len12", red, 8'hAB);
    check("R4", "len15", grn, 8'h15);
    check("R4", "len9", blu, 8'h55);
  endtask

  task automatic t_nolen();
    sel_r = mk_sel(8'h5A, 4'd0, 5'd0);
    sel_g = mk_sel(8'h99, 4'd8, 5'd0);
    sel_b = mk_sel(8'hC3, 4'd0, 5'd8);
    send(2'd3, 32'h1234_5678, 1'b1, 1'b0);
    check("R5", "len0 red", red, 8'h5A);
    check("R10", "len8 grn beside len0", grn, 8'h78);
    check("R5", "len0 blu", blu, 8'hC3);
  endtask

  task automatic t_blank();
    sel_r = mk_sel(8'h10, 4'd8, 5'd0);
    sel_g = mk_sel(8'h20, 4'd8, 5'd8);
    sel_b = mk_sel(8'h30, 4'd8, 5'd16);
    send(2'd3, 32'hFFFF_FFFF, 1'b0, 1'b0);
    check("R6", "blank red", red, 8'h10);
    check("R6", "blank grn", grn, 8'h20);
    check("R6", "blank blu", blu, 8'h30);
  endtask

  task automatic t_underrun();
    sel_r = mk_sel(8'hE1, 4'd8, 5'd0);
    sel_g = mk_sel(8'hE2, 4'd8, 5'd8);
    sel_b = mk_sel(8'hE3, 4'd8, 5'd16);
    send(2'd3, 32'h0000_0000, 1'b1, 1'b1);
    check("R7", "underrun red", red, 8'hE1);
    check("R7", "underrun grn", grn, 8'hE2);
    check("R7", "underrun blu", blu, 8'hE3);
    sel_g = mk_sel(8'h4F, 4'd8, 5'd8);
    send(2'd3, 32'h0000_0000, 1'b0, 1'b1);
    check("R7", "underrun+blank grn", grn, 8'h4F);
  endtask

  task automatic t_hold();
    sel_r = mk_sel(8'h00, 4'd8, 5'd0);
    sel_g = mk_sel(8'h00, 4'd8, 5'd8);
    sel_b = mk_sel(8'h00, 4'd8, 5'd16);
    send(2'd3, 32'h00C0_FFEE, 1'b1, 1'b0);
    check("R8", "valid pulse high", rgb_valid, 1);
    @(negedge clk);
    pix_data = 32'h0011_2233;
    sel_r    = mk_sel(8'h66, 4'd0, 5'd0);
    pix_und  = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R8", "valid low when idle", rgb_valid, 0);
    check("R9", "hold red", red, 8'hEE);
    check("R9", "hold grn", grn, 8'hFF);
    check("R9", "hold blu", blu, 8'hC0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_rgb565();
    t_rgb888();
    t_width_mask();
    t_replicate();
    t_truncate();
    t_nolen();
    t_blank();
    t_underrun();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule